// File: doc/BRIEF.md
# MDIO Clause-22 Gateway Master

This block is a register-driven management master for Ethernet PHYs. Software places one 32-bit command word in a gateway register. The word carries the PHY address, the register address, a two-bit opcode, sixteen data bits and a busy flag. Writing the word with the busy flag set starts a Clause-22 frame on the management clock and data lines. The busy flag reads back as 1 until the frame has finished. After a read, the low sixteen bits of the same gateway register hold the value that the PHY returned. Software polls busy and then reads the result from that register.

A second register sets the timing, counted in core clock cycles. It gives the half-period of the management clock, the cycle after each clock rise at which the master samples the incoming data, and the cycle at which it changes the outgoing data. The mode, voltage-select and drive-select fields of that register are held for software only and have no effect on the frame.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset the gateway register reads 0x0000_0000 and the timing register reads 0x0D06_0715. This is mode 1, voltage and drive selects set, half-period value 7, sample point 6 and change point 13. MDC and mdio_oe are low.
- R2: A write to byte offset 0x0 with bit 30 set, while no frame runs, starts a frame. Bit 30 then reads 1 for exactly 63·2(P+1)+C+1 samples, where P is the period value and C is the change point.
- R3: While a frame runs, MDC has a period of 2(P+1) core cycles. It is high for the first P+1 cycles of each period, starting in the first cycle of the frame. MDC is low whenever no frame runs.
- R4: Each frame carries 64 bits, most significant bit first. The order is 32 ones, then 0 and 1, then opcode bits 27:26, PHY address bits 25:21, register address bits 20:16, a two-bit turnaround and data bits 15:0. The bit index advances in each cycle whose phase equals the change point C.
- R5: For opcode 01 (write), mdio_oe is high for the whole frame and the turnaround is driven as 1 then 0.
- R6: For opcode 10 (read), mdio_oe goes low from bit 46 (the turnaround) to the end of the frame. mdio_i is sampled at phase S of bit periods 48 to 63, with S smaller than C. After busy clears, gateway bits 15:0 hold the sampled bits, the first one in bit 15.
- R7: A gateway write with bit 30 clear, made while a frame runs, aborts the frame. From the next cycle on, busy reads 0 and MDC and mdio_oe are low.
- R8: A gateway write with bit 30 set, made while a frame runs, is ignored. The stored command fields and the frame on the wire are unchanged.
- R9: A write to byte offset 0x4 stores bits 31:24 (change point), 23:16 (sample point), 15:8 (period value), 4, 2 and 1:0. Bits 7:5 and 3 read 0.
- R10: A gateway write with bit 30 clear, made while no frame runs, stores bits 28:0 and starts nothing. MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | BUS_AW | Byte address: 0x0 gateway, 0x4 timing |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A register write takes effect at the clock edge that captures it, so busy, MDC and the first frame bit change in the sample straight after that edge. Each bit change or data sample then lands in the cycle whose phase equals C or S. The bench holds a cycle-count model of the phase and the bit index, updated on the same edges as the design. It compares MDC, mdio_oe, mdio_o and the read data a fixed fraction of a period after every rising edge. The busy length, the read result, the abort and the ignored write are each also checked at the exact sample that the phase arithmetic gives.

// File: rtl/mdio_gw_pkg.sv
// Package mdio_gw_pkg
// Shared field positions, frame geometry and command type for the gateway master.
// Assumes a 32-bit register interface and a 64-bit Clause-22 frame.
package mdio_gw_pkg;
    localparam int CNT_W      = 8;   // width of the timing fields
    localparam int DATA_W     = 16;
    localparam int MADDR_W    = 5;
    localparam int PREAMBLE   = 32;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = PREAMBLE + 14;  // first turnaround bit
    localparam int DATA_IDX   = TA_IDX + 2;     // first data bit
    localparam int BUSY_BIT   = 30;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [31:0] CFG_KEEP = 32'hFFFF_FF17;

    // gateway command fields, bits 28:0 of the gateway word
    typedef struct packed {
        logic               st;
        logic [1:0]         op;
        logic [MADDR_W-1:0] phy;
        logic [MADDR_W-1:0] regad;
        logic [DATA_W-1:0]  data;
    } gw_cmd_t;

    // timing register layout
    typedef struct packed {
        logic [CNT_W-1:0] out_pt;
        logic [CNT_W-1:0] in_pt;
        logic [CNT_W-1:0] period;
        logic [2:0]       rsv_hi;
        logic             drive;
        logic             rsv_lo;
        logic             vsel;
        logic [1:0]       mode;
    } cfg_t;
endpackage

// File: rtl/mdio_cfg_reg.sv
// Module mdio_cfg_reg
// Holds the timing register. Reserved bits are masked on write so they read 0.
// Mode, voltage and drive selects are stored only. Assumes a pre-decoded write strobe.
module mdio_cfg_reg
    import mdio_gw_pkg::*;
#(
    parameter int RST_PERIOD = 7,
    parameter int RST_IN_PT  = 6,
    parameter int RST_OUT_PT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] in_pt,
    output logic [CNT_W-1:0] out_pt
);
    localparam cfg_t CFG_RST = '{
        out_pt: CNT_W'(RST_OUT_PT),
        in_pt:  CNT_W'(RST_IN_PT),
        period: CNT_W'(RST_PERIOD),
        rsv_hi: 3'b000,
        drive:  1'b1,
        rsv_lo: 1'b0,
        vsel:   1'b1,
        mode:   2'b01
    };

    cfg_t cfg_q;

    // store the masked write value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (wr) begin
            cfg_q <= cfg_t'(wdata & CFG_KEEP);
        end
    end

    assign rd     = cfg_q;
    assign period = cfg_q.period;
    assign in_pt  = cfg_q.in_pt;
    assign out_pt = cfg_q.out_pt;
endmodule

// File: rtl/mdio_clk_timer.sv
// Module mdio_clk_timer
// Phase counter for one MDC period of 2*(period+1) cycles. Gives MDC and the
// sample and change ticks. Assumes in_pt and out_pt lie inside the period.
module mdio_clk_timer
    import mdio_gw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] in_pt,
    input  logic [CNT_W-1:0] out_pt,
    output logic             mdc,
    output logic             smp_tick,
    output logic             chg_tick
);
    localparam int PH_W = CNT_W + 1;

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] ph_last;

    assign ph_last = {period, 1'b1};

    // phase runs 0..2P+1 while active, held at 0 otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!run || ph == ph_last) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assign mdc      = run && (ph <= {1'b0, period});
    assign smp_tick = run && (ph == {1'b0, in_pt});
    assign chg_tick = run && (ph == {1'b0, out_pt});
endmodule

// File: rtl/mdio_frame_engine.sv
// Module mdio_frame_engine
// Serialises the 64-bit Clause-22 frame and collects read data. The bit index
// advances on each change tick. Assumes the sample tick comes before the change tick.
module mdio_frame_engine
    import mdio_gw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              chg_tick,
    input  logic              smp_tick,
    input  gw_cmd_t           cmd,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              frame_done,
    output logic [IDX_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] rx_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] frame;
    logic                  is_read;
    logic                  at_last;

    assign frame   = {{PREAMBLE{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regad, 2'b10, cmd.data};
    assign is_read = (cmd.op == OP_RD);
    assign at_last = (bit_idx == LAST_IDX);

    // bit position inside the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if (!active) begin
            bit_idx <= '0;
        end else if (chg_tick && !at_last) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // shift in PHY data during the data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (!active) begin
            rx_data <= '0;
        end else if (smp_tick && bit_idx >= IDX_W'(DATA_IDX)) begin
            rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        end
    end

    assign mdio_o     = frame[LAST_IDX - bit_idx];
    assign mdio_oe    = active && !(is_read && bit_idx >= IDX_W'(TA_IDX));
    assign frame_done = active && chg_tick && at_last;
endmodule

// File: rtl/mdio_gw_master.sv
// Module mdio_gw_master
// Top of the gateway master. Decodes the two registers, holds the gateway
// command and busy flag, and runs the timer and the frame engine. Assumes
// word-aligned accesses at byte offsets 0x0 and 0x4.
module mdio_gw_master
    import mdio_gw_pkg::*;
#(
    parameter int RST_PERIOD = 7,
    parameter int RST_IN_PT  = 6,
    parameter int RST_OUT_PT = 13,
    parameter int BUS_AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam logic [BUS_AW-1:0] GW_OFS  = BUS_AW'(0);
    localparam logic [BUS_AW-1:0] CFG_OFS = BUS_AW'(4);

    logic              gw_wr;
    logic              cfg_wr;
    logic              gw_busy;
    gw_cmd_t           cmd;
    logic              frame_done;
    logic              chg_tick;
    logic              smp_tick;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rx_data;
    logic [31:0]       cfg_rd;
    logic [CNT_W-1:0]  period;
    logic [CNT_W-1:0]  in_pt;
    logic [CNT_W-1:0]  out_pt;

    assign gw_wr  = reg_wr && (reg_addr == GW_OFS);
    assign cfg_wr = reg_wr && (reg_addr == CFG_OFS);

    // gateway command, busy flag and read-back of PHY data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd     <= '0;
            gw_busy <= 1'b0;
        end else if (gw_wr && !(gw_busy && reg_wdata[BUSY_BIT])) begin
            cmd     <= gw_cmd_t'(reg_wdata[$bits(gw_cmd_t)-1:0]);
            gw_busy <= reg_wdata[BUSY_BIT];
        end else if (frame_done) begin
            gw_busy <= 1'b0;
            if (cmd.op == OP_RD) begin
                cmd.data <= rx_data;
            end
        end
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == GW_OFS) begin
            reg_rdata = {1'b0, gw_busy, 1'b0, cmd};
        end else if (reg_addr == CFG_OFS) begin
            reg_rdata = cfg_rd;
        end
    end

    mdio_cfg_reg #(
        .RST_PERIOD (RST_PERIOD),
        .RST_IN_PT  (RST_IN_PT),
        .RST_OUT_PT (RST_OUT_PT)
    ) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (reg_wdata),
        .rd     (cfg_rd),
        .period (period),
        .in_pt  (in_pt),
        .out_pt (out_pt)
    );

    mdio_clk_timer i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gw_busy),
        .period   (period),
        .in_pt    (in_pt),
        .out_pt   (out_pt),
        .mdc      (mdc),
        .smp_tick (smp_tick),
        .chg_tick (chg_tick)
    );

    mdio_frame_engine i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (gw_busy),
        .chg_tick   (chg_tick),
        .smp_tick   (smp_tick),
        .cmd        (cmd),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .frame_done (frame_done),
        .bit_idx    (bit_idx),
        .rx_data    (rx_data)
    );
endmodule

// File: rtl/mdio_gw_checker.sv
// Module mdio_gw_checker
// Temporal checks on the gateway master, bound to every instance of the top.
module mdio_gw_checker
    import mdio_gw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             gw_wr,
    input logic             wr_busy,
    input logic             gw_busy,
    input logic             frame_done,
    input logic             chg_tick,
    input logic [IDX_W-1:0] bit_idx,
    input gw_cmd_t          cmd,
    input logic             mdc,
    input logic             mdio_oe
);
    // R2: an accepted start raises busy with the frame at its first bit
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_busy && gw_wr && wr_busy) |=> (gw_busy && bit_idx == '0));

    // R3: the clock and the data driver are quiet when idle
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_busy |-> (!mdc && !mdio_oe));

    // R3: MDC is high in the first cycle of a frame
    assert_mdc_first_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gw_busy) |-> mdc);

    // R4: the bit index advances by one on a change tick
    assert_bit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_busy && chg_tick && !frame_done && !gw_wr)
        |=> (gw_busy && bit_idx == IDX_W'($past(bit_idx) + 1'b1)));

    // R7: a write with busy clear stops the frame
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_wr && !wr_busy) |=> !gw_busy);

    // R8: a write with busy set during a frame leaves the command alone
    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_busy && gw_wr && wr_busy && !frame_done) |=> (gw_busy && $stable(cmd)));
endmodule

bind mdio_gw_master mdio_gw_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gw_wr      (gw_wr),
    .wr_busy    (reg_wdata[30]),
    .gw_busy    (gw_busy),
    .frame_done (frame_done),
    .chg_tick   (chg_tick),
    .bit_idx    (bit_idx),
    .cmd        (cmd),
    .mdc        (mdc),
    .mdio_oe    (mdio_oe)
);

// File: tb/test_mdio_gw_master.sv
// Bench for mdio_gw_master: a behavioural cycle-count model, compared every cycle.
module test_mdio_gw_master;
    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_gw_master i_mdio_gw_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- reference model ----------------
    logic        m_busy;
    int          m_t;
    logic [28:0] m_cmd;
    logic [31:0] m_cfg;
    logic [15:0] phy_val = 16'h0000;

    int   e_tp, e_ph, e_k, e_idx, e_per, e_in, e_out;
    logic e_done, e_read, e_mdc, e_oe, e_mo, e_phy_bit;
    logic [63:0] e_frame;
    logic [31:0] e_rdata;

    always_comb begin
        e_per   = int'(m_cfg[15:8]);
        e_in    = int'(m_cfg[23:16]);
        e_out   = int'(m_cfg[31:24]);
        e_tp    = 2 * (e_per + 1);
        e_ph    = m_t % e_tp;
        e_k     = m_t / e_tp;
        e_idx   = e_k + ((e_ph > e_out) ? 1 : 0);
        e_read  = (m_cmd[27:26] == 2'b10);
        e_done  = m_busy && (e_ph == e_out) && (e_k == 63);
        e_mdc   = m_busy && (e_ph <= e_per);
        e_oe    = m_busy && !(e_read && e_idx >= 46);
        e_frame = {32'hFFFF_FFFF, 2'b01, m_cmd[27:26], m_cmd[25:21], m_cmd[20:16], 2'b10, m_cmd[15:0]};
        e_mo    = (e_idx < 64) ? e_frame[63 - e_idx] : 1'b1;
        e_phy_bit = (m_busy && e_read && e_idx >= 48 && e_idx < 64) ? phy_val[63 - e_idx] : 1'b1;
        if (reg_addr == 3'd0)      e_rdata = {1'b0, m_busy, 1'b0, m_cmd};
        else if (reg_addr == 3'd4) e_rdata = m_cfg;
        else                       e_rdata = 32'd0;
    end

    assign mdio_i = e_phy_bit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_t    <= 0;
            m_cmd  <= '0;
            m_cfg  <= 32'h0D06_0715;
        end else begin
            if (reg_wr && reg_addr == 3'd0 && !(m_busy && reg_wdata[30])) begin
                m_cmd  <= reg_wdata[28:0];
                m_busy <= reg_wdata[30];
                m_t    <= 0;
            end else if (e_done) begin
                m_busy <= 1'b0;
                if (e_read) m_cmd[15:0] <= phy_val;
            end else if (m_busy) begin
                m_t <= m_t + 1;
            end
            if (reg_wr && reg_addr == 3'd4) m_cfg <= reg_wdata & 32'hFFFF_FF17;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison after each rising edge
    always begin
        @(posedge clk);
        #SAMPLE_DLY;
        if (rst_n) begin
            chk("R3 mdc", {31'd0, mdc}, {31'd0, e_mdc});
            chk(e_read ? "R6 mdio_oe" : "R5 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            if (e_oe) chk("R4 mdio_o", {31'd0, mdio_o}, {31'd0, e_mo});
            chk(reg_addr == 3'd4 ? "R9 rdata" : "R2 rdata", reg_rdata, e_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0;
    endtask

    task automatic sample_point();
        @(posedge clk);
        #SAMPLE_DLY;
    endtask

    task automatic wait_idle(output int busy_cnt);
        busy_cnt = 1;  // the sample right after the accepting edge
        for (int i = 0; i < 5000; i++) begin
            sample_point();
            if (!reg_rdata[30]) break;
            busy_cnt++;
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic busy, input logic [1:0] op,
                                             input logic [4:0] phy, input logic [4:0] ra,
                                             input logic [15:0] d);
        return {1'b0, busy, 1'b0, 1'b1, op, phy, ra, d};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [31:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        sample_point();
        chk("R1 gateway reset", reg_rdata, 32'h0000_0000);
        chk("R1 mdc reset", {31'd0, mdc}, 32'd0);
        chk("R1 oe reset", {31'd0, mdio_oe}, 32'd0);
        @(negedge clk); reg_addr = 3'd4;
        sample_point();
        chk("R1 timing reset", reg_rdata, 32'h0D06_0715);
        @(negedge clk); reg_addr = 3'd0;

        // R2/R5: write frame at reset timing (P=7, C=13)
        wr(3'd0, cmd_word(1'b1, 2'b01, 5'h11, 5'h0A, 16'hA5C3));
        wait_idle(cnt);
        chk("R2 busy length P7", cnt, 63 * 16 + 13 + 1);

        // R9: timing write with reserved bits set, P=2 S=1 C=4
        wr(3'd4, {8'd4, 8'd1, 8'd2, 8'hFF});
        @(negedge clk); reg_addr = 3'd4;
        sample_point();
        chk("R9 timing readback", reg_rdata, 32'h0401_0217);
        @(negedge clk); reg_addr = 3'd0;

        // R6: read frame
        phy_val = 16'h9E37;
        wr(3'd0, cmd_word(1'b1, 2'b10, 5'h03, 5'h02, 16'h0000));
        wait_idle(cnt);
        chk("R2 busy length P2", cnt, 63 * 6 + 4 + 1);
        chk("R6 read result", {16'd0, reg_rdata[15:0]}, {16'd0, 16'h9E37});

        // second read with another pattern
        phy_val = 16'h4A81;
        wr(3'd0, cmd_word(1'b1, 2'b10, 5'h1F, 5'h1E, 16'hFFFF));
        wait_idle(cnt);
        chk("R6 read result 2", {16'd0, reg_rdata[15:0]}, {16'd0, 16'h4A81});

        // R8: a busy-set write during a frame is ignored
        w = cmd_word(1'b1, 2'b01, 5'h05, 5'h13, 16'h1234);
        wr(3'd0, w);
        repeat (100) @(negedge clk);
        wr(3'd0, cmd_word(1'b1, 2'b10, 5'h1A, 5'h07, 16'hBEEF));
        sample_point();
        chk("R8 command unchanged", reg_rdata, w);
        wait_idle(cnt);
        chk("R8 data kept after write frame", {16'd0, reg_rdata[15:0]}, 32'h0000_1234);

        // R7: abort a read part-way
        phy_val = 16'h0F0F;
        wr(3'd0, cmd_word(1'b1, 2'b10, 5'h09, 5'h04, 16'h0000));
        repeat (150) @(negedge clk);
        wr(3'd0, 32'h0000_0000);
        sample_point();
        chk("R7 busy after abort", {31'd0, reg_rdata[30]}, 32'd0);
        chk("R7 mdc after abort", {31'd0, mdc}, 32'd0);
        chk("R7 oe after abort", {31'd0, mdio_oe}, 32'd0);

        // R10: idle write with busy clear starts nothing
        wr(3'd0, 32'h1ABC_5678);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            sample_point();
            if (mdc) cnt++;
        end
        chk("R10 no mdc activity", cnt, 0);
        chk("R10 word stored", reg_rdata, 32'h1ABC_5678);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule